// File: doc/BRIEF.md
# Character Raster Timing Controller

This block generates the raster timing for a text-mode display. It counts character clocks across a line, scan lines within a character row, and character rows within a frame. From those counts it drives horizontal sync, vertical sync, a display-enable that marks the visible area, a 14-bit refresh address into character memory, and a 5-bit scan-line number for an external character generator. A cursor output marks the character cell whose address matches a programmed cursor address, limited to a band of scan lines and gated by a blink mode. A one-clock interrupt pulse marks the end of the visible rows.

A host programs the block through an index/data pair. A write with the select input low picks a register. A write with the select input high loads that register. Every loaded value waits in a pending copy and takes effect only at the next frame boundary, so a frame never changes shape partway through. Most geometry values hold a count minus one. The start address lets software scroll the picture by moving the memory window.

Top module: `crtc_timing`

## Requirements
- R1: While reset is held, all counters and the frame counter are zero, and the refresh address and scan-line output are 0. Sync and interrupt are low. The active and pending registers take their defaults: index 0=9, 1=5, 2=7, 3=2, 4=3, 6=1, 7=2, 9=1, 10=0x00, 11=1, 12=0, 13=0, 14=0, 15=0.
- R2: On a clock with `hostWe` high, `hostSel`=0 latches `hostData[3:0]` as the register index, and `hostSel`=1 writes `hostData` into the pending register at that index. Indices 5 and 8 hold nothing, and writes to them change no output.
- R3: A line lasts (index 0)+1 character clocks. The horizontal count runs from 0 up to that value and then returns to 0.
- R4: `dispEn` is high only while the horizontal count is at most index 1 and the row count is at most index 6 (bits 6:0).
- R5: `hSync` is high while the horizontal count c satisfies P <= c < P+W. Here P is index 2 and W is index 3 bits 3:0. W=0 gives no pulse.
- R6: `vSync` rises with the first scan line of row index 7 (bits 6:0) and stays high for 16 scan lines. A new start within that window restarts the 16 lines.
- R7: `rowAddr` counts scan lines from 0 to index 9 (bits 4:0), and then the row count advances. The row count returns to 0 after index 4 (bits 6:0).
- R8: At each frame start, `refAddr` equals the start address {index 12 bits 5:0, index 13}. It rises by one per clock along a line, modulo 2^14. Each scan line restarts from the base of its character row. The row base grows by (index 1)+1 when a row completes.
- R9: `cursorOut` is high when all of the following hold: `dispEn` is high, `refAddr` equals {index 14 bits 5:0, index 15}, and the scan line lies between index 10 bits 4:0 and index 11 bits 4:0 inclusive. The blink field (index 10 bits 6:5) sets the visible phase: 00 always on, 01 always off, 10 on while bit 3 of a 5-bit frame counter is 0, and 11 on while bit 4 is 0. The frame counter counts completed frames.
- R10: `vblankIrq` is high for exactly the one clock that follows the last clock of row index 6, meaning its last scan line and its last character.
- R11: Pending values are copied into the active set on the clock that follows a frame's last clock. Until then, a write has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWe | input | 1 | Host write strobe |
| hostSel | input | 1 | 0 selects the index, 1 selects the data register |
| hostData | input | 8 | Host write data |
| hSync | output | 1 | Horizontal sync pulse |
| vSync | output | 1 | Vertical sync pulse |
| dispEn | output | 1 | High in the visible area |
| rowAddr | output | 5 | Scan line within the character row |
| refAddr | output | 14 | Character memory refresh address |
| cursorOut | output | 1 | Cursor cell marker |
| vblankIrq | output | 1 | One-clock pulse when the visible rows end |

## Verification
The assertions assume that host inputs change only away from the rising clock edge and that `hostData` is a defined 8-bit value whenever `hostWe` is high. They need no ordering between the geometry registers: any combination of totals, displayed counts and sync positions keeps them valid, including sync positions that lie beyond the total. The stimulus drives host writes at falling edges and reprograms in mid-frame to exercise the deferral. Its configurations cover a refresh window that wraps past 2^14, a zero-width horizontal sync, a displayed row count equal to the total, a vertical sync shorter frame than 16 scan lines, and both timed blink modes held for enough frames to see each phase.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 4;
  localparam int H_W     = 8;
  localparam int V_W     = 7;
  localparam int RA_W    = 5;
  localparam int MA_W    = 14;
  localparam int HSW_W   = 4;
  localparam int BLINK_W = 5;
  localparam int MA_HI_W = MA_W - DATA_W;

  localparam logic [IDX_W-1:0] IX_HTOTAL  = 4'd0;
  localparam logic [IDX_W-1:0] IX_HDISP   = 4'd1;
  localparam logic [IDX_W-1:0] IX_HSPOS   = 4'd2;
  localparam logic [IDX_W-1:0] IX_HSWIDTH = 4'd3;
  localparam logic [IDX_W-1:0] IX_VTOTAL  = 4'd4;
  localparam logic [IDX_W-1:0] IX_VDISP   = 4'd6;
  localparam logic [IDX_W-1:0] IX_VSPOS   = 4'd7;
  localparam logic [IDX_W-1:0] IX_MAXSCAN = 4'd9;
  localparam logic [IDX_W-1:0] IX_CURTOP  = 4'd10;
  localparam logic [IDX_W-1:0] IX_CURBOT  = 4'd11;
  localparam logic [IDX_W-1:0] IX_STARTHI = 4'd12;
  localparam logic [IDX_W-1:0] IX_STARTLO = 4'd13;
  localparam logic [IDX_W-1:0] IX_CURHI   = 4'd14;
  localparam logic [IDX_W-1:0] IX_CURLO   = 4'd15;

  typedef enum logic [1:0] {
    BLINK_STEADY = 2'b00,
    BLINK_HIDDEN = 2'b01,
    BLINK_FAST   = 2'b10,
    BLINK_SLOW   = 2'b11
  } blinkMode_e;

  typedef struct packed {
    logic [H_W-1:0]   hTotal;
    logic [H_W-1:0]   hDisp;
    logic [H_W-1:0]   hSyncPos;
    logic [HSW_W-1:0] hSyncWidth;
    logic [V_W-1:0]   vTotal;
    logic [V_W-1:0]   vDisp;
    logic [V_W-1:0]   vSyncPos;
    logic [RA_W-1:0]  maxScan;
    logic [RA_W-1:0]  curTop;
    logic [RA_W-1:0]  curBot;
    blinkMode_e       blinkMode;
    logic [MA_W-1:0]  startAddr;
    logic [MA_W-1:0]  curAddr;
  } timingRegs_t;

  typedef struct packed {
    logic lineEnd;
    logic rowEnd;
    logic frameEnd;
  } ctrlStrobe_t;

  localparam timingRegs_t REG_DEFAULTS = '{
    hTotal:     8'd9,
    hDisp:      8'd5,
    hSyncPos:   8'd7,
    hSyncWidth: 4'd2,
    vTotal:     7'd3,
    vDisp:      7'd1,
    vSyncPos:   7'd2,
    maxScan:    5'd1,
    curTop:     5'd0,
    curBot:     5'd1,
    blinkMode:  BLINK_STEADY,
    startAddr:  14'd0,
    curAddr:    14'd0
  };
endpackage

// File: rtl/crtc_hostregs.sv
module crtc_hostregs
  import crtc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic               hostSel,
  input  logic [DATA_W-1:0]  hostData,
  input  logic               frameEnd,
  output timingRegs_t        activeRegs,
  output logic [MA_W-1:0]    pendStart
);
  logic [IDX_W-1:0] idxQ;
  timingRegs_t      pendRegs;
  timingRegs_t      actRegs;

  // Host port: index latch and pending register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ     <= '0;
      pendRegs <= REG_DEFAULTS;
    end else if (hostWe) begin
      if (!hostSel) begin
        idxQ <= hostData[IDX_W-1:0];
      end else begin
        case (idxQ)
          IX_HTOTAL:  pendRegs.hTotal     <= hostData[H_W-1:0];
          IX_HDISP:   pendRegs.hDisp      <= hostData[H_W-1:0];
          IX_HSPOS:   pendRegs.hSyncPos   <= hostData[H_W-1:0];
          IX_HSWIDTH: pendRegs.hSyncWidth <= hostData[HSW_W-1:0];
          IX_VTOTAL:  pendRegs.vTotal     <= hostData[V_W-1:0];
          IX_VDISP:   pendRegs.vDisp      <= hostData[V_W-1:0];
          IX_VSPOS:   pendRegs.vSyncPos   <= hostData[V_W-1:0];
          IX_MAXSCAN: pendRegs.maxScan    <= hostData[RA_W-1:0];
          IX_CURTOP: begin
            pendRegs.curTop    <= hostData[RA_W-1:0];
            pendRegs.blinkMode <= blinkMode_e'(hostData[RA_W+1:RA_W]);
          end
          IX_CURBOT:  pendRegs.curBot     <= hostData[RA_W-1:0];
          IX_STARTHI: pendRegs.startAddr[MA_W-1:DATA_W] <= hostData[MA_HI_W-1:0];
          IX_STARTLO: pendRegs.startAddr[DATA_W-1:0]    <= hostData;
          IX_CURHI:   pendRegs.curAddr[MA_W-1:DATA_W]   <= hostData[MA_HI_W-1:0];
          IX_CURLO:   pendRegs.curAddr[DATA_W-1:0]      <= hostData;
          default: ;
        endcase
      end
    end
  end

  // Active copy only moves at a frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) actRegs <= REG_DEFAULTS;
    else if (frameEnd) actRegs <= pendRegs;
  end

  assign activeRegs = actRegs;
  assign pendStart  = pendRegs.startAddr;

  // R11: active set never moves except right after a frame end
  p_hold_midframe_r11: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(actRegs));
endmodule

// File: rtl/crtc_ctrl.sv
module crtc_ctrl
  import crtc_pkg::*;
#(
  parameter int VS_LINES = 16
)(
  input  logic             clk,
  input  logic             rstN,
  input  timingRegs_t      regs,
  output ctrlStrobe_t      strobe,
  output logic [H_W-1:0]   hCnt,
  output logic [RA_W-1:0]  scanCnt,
  output logic             dispEn,
  output logic             hSync,
  output logic             vSync,
  output logic             vblankIrq
);
  localparam int VS_W = $clog2(VS_LINES + 1);

  logic [V_W-1:0]  rowCnt;
  logic [VS_W-1:0] vsCnt;
  logic            irqQ;
  logic            lineEnd, rowEnd, frameEnd;
  logic [RA_W-1:0] nextScan;
  logic [V_W-1:0]  nextRow;
  logic            vsStart;
  logic [H_W:0]    hsEnd;

  assign lineEnd  = (hCnt == regs.hTotal);
  assign rowEnd   = lineEnd && (scanCnt == regs.maxScan);
  assign frameEnd = rowEnd && (rowCnt == regs.vTotal);
  assign nextScan = rowEnd ? '0 : scanCnt + RA_W'(1);
  assign nextRow  = frameEnd ? '0 : (rowEnd ? rowCnt + V_W'(1) : rowCnt);
  assign vsStart  = lineEnd && (nextRow == regs.vSyncPos) && (nextScan == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt    <= '0;
      scanCnt <= '0;
      rowCnt  <= '0;
    end else begin
      hCnt <= lineEnd ? '0 : hCnt + H_W'(1);
      if (lineEnd) begin
        scanCnt <= nextScan;
        rowCnt  <= nextRow;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vsCnt <= '0;
    else if (lineEnd) begin
      if (vsStart) vsCnt <= VS_W'(VS_LINES);
      else if (vsCnt != '0) vsCnt <= vsCnt - VS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else irqQ <= rowEnd && (rowCnt == regs.vDisp);
  end

  assign hsEnd     = {1'b0, regs.hSyncPos} + (H_W+1)'(regs.hSyncWidth);
  assign hSync     = (hCnt >= regs.hSyncPos) && ({1'b0, hCnt} < hsEnd);
  assign vSync     = (vsCnt != '0);
  assign dispEn    = (hCnt <= regs.hDisp) && (rowCnt <= regs.vDisp);
  assign vblankIrq = irqQ;

  assign strobe.lineEnd  = lineEnd;
  assign strobe.rowEnd   = rowEnd;
  assign strobe.frameEnd = frameEnd;

  // R3: the character counter restarts after the line total
  p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> (hCnt == '0));
  // R7: the scan-line counter restarts after the last scan line of a row
  p_scan_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    rowEnd |=> (scanCnt == '0));
  // R5: a zero width never yields a pulse
  p_hsync_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regs.hSyncWidth == '0) |-> !hSync);
  // R6: a vertical sync start is visible on the next line
  p_vsync_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    vsStart |=> vSync);
endmodule

// File: rtl/crtc_datapath.sv
module crtc_datapath
  import crtc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  timingRegs_t      regs,
  input  logic [MA_W-1:0]  pendStart,
  input  ctrlStrobe_t      strobe,
  input  logic [H_W-1:0]   hCnt,
  input  logic [RA_W-1:0]  scanCnt,
  input  logic             dispEn,
  output logic [MA_W-1:0]  refAddr,
  output logic             cursorOut
);
  logic [MA_W-1:0]    rowBase;
  logic [MA_W-1:0]    maQ;
  logic [MA_W-1:0]    rowNext;
  logic [BLINK_W-1:0] frameCnt;
  logic               blinkOn;
  logic               inBand;

  assign rowNext = rowBase + MA_W'(regs.hDisp) + MA_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowBase <= REG_DEFAULTS.startAddr;
      maQ     <= REG_DEFAULTS.startAddr;
    end else if (strobe.frameEnd) begin
      rowBase <= pendStart;
      maQ     <= pendStart;
    end else if (strobe.rowEnd) begin
      rowBase <= rowNext;
      maQ     <= rowNext;
    end else if (strobe.lineEnd) begin
      maQ <= rowBase;
    end else begin
      maQ <= maQ + MA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameCnt <= '0;
    else if (strobe.frameEnd) frameCnt <= frameCnt + BLINK_W'(1);
  end

  always_comb begin
    case (regs.blinkMode)
      BLINK_STEADY: blinkOn = 1'b1;
      BLINK_HIDDEN: blinkOn = 1'b0;
      BLINK_FAST:   blinkOn = !frameCnt[3];
      default:      blinkOn = !frameCnt[4];
    endcase
  end

  assign inBand    = (scanCnt >= regs.curTop) && (scanCnt <= regs.curBot);
  assign cursorOut = dispEn && blinkOn && inBand && (maQ == regs.curAddr);
  assign refAddr   = maQ;

  // R8: refresh address tracks row base plus the character count
  p_ma_track_r8: assert property (@(posedge clk) disable iff (!rstN)
    maQ == rowBase + MA_W'(hCnt));
  // R9: the cursor only shows inside the visible area
  p_cursor_vis_r9: assert property (@(posedge clk) disable iff (!rstN)
    cursorOut |-> dispEn);
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
#(
  parameter int VS_LINES = 16
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic        hostSel,
  input  logic [7:0]  hostData,
  output logic        hSync,
  output logic        vSync,
  output logic        dispEn,
  output logic [4:0]  rowAddr,
  output logic [13:0] refAddr,
  output logic        cursorOut,
  output logic        vblankIrq
);
  timingRegs_t      activeRegs;
  logic [MA_W-1:0]  pendStart;
  ctrlStrobe_t      strobe;
  logic [H_W-1:0]   hCnt;
  logic [RA_W-1:0]  scanCnt;
  logic             dispEnInt;

  crtc_hostregs regs_i (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostData(hostData), .frameEnd(strobe.frameEnd),
    .activeRegs(activeRegs), .pendStart(pendStart)
  );

  crtc_ctrl #(.VS_LINES(VS_LINES)) ctrl_i (
    .clk(clk), .rstN(rstN), .regs(activeRegs), .strobe(strobe),
    .hCnt(hCnt), .scanCnt(scanCnt), .dispEn(dispEnInt),
    .hSync(hSync), .vSync(vSync), .vblankIrq(vblankIrq)
  );

  crtc_datapath dp_i (
    .clk(clk), .rstN(rstN), .regs(activeRegs), .pendStart(pendStart),
    .strobe(strobe), .hCnt(hCnt), .scanCnt(scanCnt), .dispEn(dispEnInt),
    .refAddr(refAddr), .cursorOut(cursorOut)
  );

  assign dispEn  = dispEnInt;
  assign rowAddr = scanCnt;
endmodule

// File: tb/crtc_timing_tb_top.sv
module crtc_timing_tb_top;
  localparam int VS = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0, hostWe = 1'b0, hostSel = 1'b0;
  logic [7:0]  hostData = 8'h00;
  logic        hSync, vSync, dispEn, cursorOut, vblankIrq;
  logic [4:0]  rowAddr;
  logic [13:0] refAddr;

  crtc_timing dut_i (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostData(hostData), .hSync(hSync), .vSync(vSync), .dispEn(dispEn),
    .rowAddr(rowAddr), .refAddr(refAddr), .cursorOut(cursorOut),
    .vblankIrq(vblankIrq)
  );

  int nChecks = 0, nFails = 0;
  string phase = "R1 reset";

  typedef struct packed {
    logic de, hs, vs;
    logic [4:0] ra;
    logic [13:0] ma;
    logic cur, irq;
  } exp_t;
  exp_t expQ[$];

  // Reference model state
  int aR[16], pR[16];
  int idx, h, s, r, vsc, rowBase, ma, fc, irq;
  int nh, ns, nr, startP;
  bit le, re, fe, irqN;

  function automatic bit validIdx(int i);
    return !(i == 5 || i == 8);
  endfunction

  function void modelReset();
    for (int i = 0; i < 16; i++) aR[i] = 0;
    aR[0] = 9; aR[1] = 5; aR[2] = 7; aR[3] = 2; aR[4] = 3;
    aR[6] = 1; aR[7] = 2; aR[9] = 1; aR[10] = 0; aR[11] = 1;
    pR = aR;
    idx = 0; h = 0; s = 0; r = 0; vsc = 0; rowBase = 0; ma = 0; fc = 0; irq = 0;
  endfunction

  function exp_t expected();
    exp_t e;
    int curA, mode;
    bit blink;
    curA = ((aR[14] & 63) << 8) | aR[15];
    mode = (aR[10] >> 5) & 3;
    blink = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 :
            (mode == 2) ? !fc[3] : !fc[4];
    e.de  = (h <= aR[1]) && (r <= (aR[6] & 127));
    e.hs  = (h >= aR[2]) && (h < aR[2] + (aR[3] & 15));
    e.vs  = (vsc != 0);
    e.ra  = s[4:0];
    e.ma  = ma[13:0];
    e.cur = e.de && blink && (ma == curA) && (s >= (aR[10] & 31)) && (s <= (aR[11] & 31));
    e.irq = irq[0];
    return e;
  endfunction

  // Driver side of the scoreboard: model steps on each edge and queues the result
  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      le = (h == aR[0]);
      re = le && (s == (aR[9] & 31));
      fe = re && (r == (aR[4] & 127));
      irqN = re && (r == (aR[6] & 127));
      ns = re ? 0 : s + 1;
      nr = fe ? 0 : (re ? r + 1 : r);
      if (le) begin
        if (nr == (aR[7] & 127) && ns == 0) vsc = VS;
        else if (vsc != 0) vsc = vsc - 1;
      end
      startP = ((pR[12] & 63) << 8) | pR[13];
      if (fe) begin rowBase = startP; ma = startP; end
      else if (re) begin rowBase = (rowBase + aR[1] + 1) & 16383; ma = rowBase; end
      else if (le) ma = rowBase;
      else ma = (ma + 1) & 16383;
      if (fe) fc = (fc + 1) & 31;
      h = le ? 0 : h + 1;
      if (le) begin s = ns; r = nr; end
      irq = irqN;
      if (fe) aR = pR;
      if (hostWe) begin
        if (!hostSel) idx = hostData & 15;
        else if (validIdx(idx)) pR[idx] = hostData;
      end
    end
    expQ.push_back(expected());
  end

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s [%s] at %0t: actual=%0h expected=%0h", tag, phase, $time, act, exp);
    end
  endtask

  // Monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk("R4 dispEn", dispEn, e.de);
      chk("R5 hSync", hSync, e.hs);
      chk("R6 vSync", vSync, e.vs);
      chk("R7 rowAddr", rowAddr, e.ra);
      chk("R3 R8 refAddr", refAddr, e.ma);
      chk("R9 cursorOut", cursorOut, e.cur);
      chk("R10 vblankIrq", vblankIrq, e.irq);
    end
  end

  task automatic hostWrite(int index, int value);
    @(negedge clk); hostWe = 1'b1; hostSel = 1'b0; hostData = index[7:0];
    @(negedge clk); hostSel = 1'b1; hostData = value[7:0];
    @(negedge clk); hostWe = 1'b0; hostSel = 1'b0;
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    phase = "R3 R7 default geometry";
    repeat (400) @(negedge clk);

    // Mid-frame reprogramming: 14-bit wrap of the refresh window
    phase = "R11 deferred reprogram A";
    hostWrite(0, 19);  hostWrite(1, 11); hostWrite(2, 13); hostWrite(3, 3);
    hostWrite(4, 9);   hostWrite(6, 5);  hostWrite(7, 7);  hostWrite(9, 2);
    hostWrite(10, 8'h01); hostWrite(11, 2);
    hostWrite(12, 8'hFF); hostWrite(13, 8'hF0);
    hostWrite(14, 8'h3F); hostWrite(15, 8'hF5);
    repeat (3000) @(negedge clk);

    phase = "R2 unused index writes";
    hostWrite(5, 8'hFF); hostWrite(8, 8'hFF);
    hostWrite(8'hF5, 8'hAA);
    repeat (1300) @(negedge clk);

    // No hsync, irq at frame end, vsync from row 0, fast blink
    phase = "R9 fast blink config B";
    hostWrite(0, 7);  hostWrite(1, 5);  hostWrite(2, 2);  hostWrite(3, 0);
    hostWrite(4, 3);  hostWrite(6, 3);  hostWrite(7, 0);  hostWrite(9, 4);
    hostWrite(10, 8'h40); hostWrite(11, 4);
    hostWrite(12, 8'h01); hostWrite(13, 8'h23);
    hostWrite(14, 8'h01); hostWrite(15, 8'h24);
    repeat (7000) @(negedge clk);

    phase = "R9 slow blink config C";
    hostWrite(10, 8'h62); hostWrite(3, 15);
    repeat (11500) @(negedge clk);

    phase = "R9 hidden cursor";
    hostWrite(10, 8'h20);
    repeat (500) @(negedge clk);
    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired [%s]", phase);
    finish();
  end
endmodule